// File: doc/BRIEF.md
# I2C Configuration Register Target

This block is an I2C target that gives a bus host access to a small bank of 8-bit configuration registers. It runs on a system clock. It passes SCL and SDA through a short synchroniser and finds START, repeated START and STOP from those copies. A 7-bit device address, set by a parameter, selects the block. The SDA pin is open drain: the block only ever pulls it low, through an output enable, and releases it otherwise.

A write carries the device address with the direction bit clear, one register-index byte and one data byte. A read first writes the register index, then sends a repeated START and the address with the direction bit set. The target answers with one byte and the host closes with NACK and STOP. The chip side reaches the same bank through a parallel port that writes on the clock edge and reads combinationally. A hardware enable input shuts the whole bus interface off. The run bit held in register 0 only drives the `core_run` output, so the bus keeps working while that bit is clear.

Top module: `i2c_reg_target`

## Requirements
- R1: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. After reset `sda_oe` is 0, register 0 holds 0x01 and every other register holds 0x00.
- R2: A device address equal to parameter DEV_ADDR (default 7'h48) is acknowledged: `sda_oe` is 1 while SCL is high in the ninth pulse. Any other address gets no acknowledge, and the target then stays silent until the next START or STOP.
- R3: A write made of START, address with direction bit 0, register index, data byte and STOP gets an acknowledge after each of its three bytes and stores the data byte in the indexed register. Bits travel MSB first.
- R4: The stored value changes on the SCL falling edge that ends the data byte's least significant bit. `par_rdata` shows the old value up to the second rising `clk` edge after `scl_i` falls and the new value after the third, before any STOP.
- R5: A read made of register index, repeated START, address with direction bit 1, eight data bits and a host NACK returns the indexed register MSB first. `sda_oe` changes only while SCL is low, and it is 0 during the NACK pulse.
- R6: While `hw_en` is 0, `sda_oe` stays 0, no byte is acknowledged and no register changes.
- R7: `core_run` equals bit 0 of register 0. Writing 0 to that bit does not stop the bus: later writes and reads are still acknowledged and served.
- R8: A register index of NREGS or more is acknowledged, but a write to it changes no register and a read from it returns 0x00.
- R9: When `par_we` is 1 at a rising `clk` edge, `par_wdata` is stored at `par_addr`. `par_rdata` shows the register at `par_addr` combinationally. When a bus commit and a parallel write hit the same register in the same cycle, the bus byte is kept.
- R10: A STOP or repeated START is accepted after any acknowledged byte. A STOP right after the register index changes no register, and a second data byte in one write is neither acknowledged nor stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_en | input | 1 | Hardware enable of the bus interface |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |
| par_we | input | 1 | Parallel port write strobe |
| par_addr | input | AW | Parallel port register index |
| par_wdata | input | 8 | Parallel port write data |
| par_rdata | output | 8 | Parallel port read data |
| core_run | output | 1 | Run bit, bit 0 of register 0 |

## Verification
A bus commit can land in the same clock cycle as a parallel-port write to the same register. The bench sets this up by counting `clk` edges after it drops SCL at the end of the data byte's last bit, and it raises `par_we` so that the strobe is sampled on exactly the third rising edge. It then reads `par_rdata` after that edge. The bus byte must be there and the parallel byte must have been lost, and a checker property states the same rule for every cycle.

// File: rtl/i2c_reg_target_pkg.sv
package i2c_reg_target_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV_ADDR,
        ST_DEV_ACK,
        ST_REG_ADDR,
        ST_REG_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_SKIP
    } tgt_state_e;

    localparam int BYTE_W  = 8;
    localparam int RUN_BIT = 0;

    function automatic logic [BYTE_W-1:0] reg_reset_value(input int idx);
        return (idx == 0) ? 8'h01 : 8'h00;
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_sh;
    logic [STAGES-1:0] sda_sh;
    logic              scl_q;
    logic              sda_q;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= scl_i;
                    sda_sh <= sda_i;
                end
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sh <= '1;
                    sda_sh <= '1;
                end else begin
                    scl_sh <= {scl_sh[STAGES-2:0], scl_i};
                    sda_sh <= {sda_sh[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_s     = scl_sh[STAGES-1];
    assign sda_s     = sda_sh[STAGES-1];
    assign scl_rise  = ~scl_q & scl_s;
    assign scl_fall  = scl_q & ~scl_s;
    assign start_det = scl_q & scl_s & sda_q & ~sda_s;
    assign stop_det  = scl_q & scl_s & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_target_fsm.sv
module i2c_target_fsm
    import i2c_reg_target_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_s,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [BYTE_W-1:0] reg_ptr,
    output logic [BYTE_W-1:0] wr_data
);

    localparam logic [3:0] FULL = 4'(BYTE_W);

    tgt_state_e        state;
    tgt_state_e        nxt;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic              rw;
    logic              byte_full;
    logic              bit_state;

    assign byte_full = (bitcnt == FULL);
    assign bit_state = (state == ST_DEV_ADDR) || (state == ST_REG_ADDR) ||
                       (state == ST_WR_DATA)  || (state == ST_RD_DATA);

    // next-state logic
    always_comb begin
        nxt = state;
        if (!hw_en) begin
            nxt = ST_IDLE;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else if (start_det) begin
            nxt = ST_DEV_ADDR;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_DEV_ADDR: if (scl_fall && byte_full)
                                 nxt = (rx_sr[7:1] == DEV_ADDR) ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK:  if (scl_fall) nxt = rw ? ST_RD_DATA : ST_REG_ADDR;
                ST_REG_ADDR: if (scl_fall && byte_full) nxt = ST_REG_ACK;
                ST_REG_ACK:  if (scl_fall) nxt = ST_WR_DATA;
                ST_WR_DATA:  if (scl_fall && byte_full) nxt = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nxt = ST_SKIP;
                ST_RD_DATA:  if (scl_fall && byte_full) nxt = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nxt = ST_SKIP;
                ST_SKIP:     nxt = ST_SKIP;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // bit counter and shift registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
            rw      <= 1'b0;
            reg_ptr <= '0;
        end else if (!hw_en || start_det || stop_det) begin
            bitcnt <= '0;
        end else begin
            if (bit_state && scl_rise && !byte_full) begin
                bitcnt <= bitcnt + 4'd1;
                rx_sr  <= {rx_sr[BYTE_W-2:0], sda_s};
            end
            if (bit_state && scl_fall && byte_full) begin
                bitcnt <= '0;
            end
            if (state == ST_DEV_ADDR && scl_fall && byte_full) begin
                rw <= rx_sr[0];
            end
            if (state == ST_REG_ADDR && scl_fall && byte_full) begin
                reg_ptr <= rx_sr;
            end
            if (state == ST_DEV_ACK && scl_fall && rw) begin
                tx_sr <= rd_data;
            end
            if (state == ST_RD_DATA && scl_fall && !byte_full) begin
                tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        wr_en  = 1'b0;
        if (hw_en) begin
            unique case (state)
                ST_DEV_ACK, ST_REG_ACK, ST_WR_ACK: sda_oe = 1'b1;
                ST_RD_DATA: sda_oe = ~tx_sr[BYTE_W-1];
                ST_WR_DATA: wr_en  = scl_fall && byte_full;
                ST_IDLE, ST_DEV_ADDR, ST_REG_ADDR, ST_RD_ACK, ST_SKIP: sda_oe = 1'b0;
                default: sda_oe = 1'b0;
            endcase
        end
    end

    assign wr_data = rx_sr;

endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank
    import i2c_reg_target_pkg::*;
#(
    parameter int NREGS = 4,
    parameter int AW    = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [BYTE_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              par_we,
    input  logic [AW-1:0]     par_addr,
    input  logic [BYTE_W-1:0] par_wdata,
    output logic [BYTE_W-1:0] par_rdata,
    output logic              run_bit
);

    localparam logic [BYTE_W-1:0] LIMIT = BYTE_W'(NREGS);

    logic [BYTE_W-1:0] regs [NREGS];
    logic              bus_in_range;

    assign bus_in_range = (bus_addr < LIMIT);

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_reg
            logic bus_hit;
            logic par_hit;
            assign bus_hit = bus_we && bus_in_range && (bus_addr[AW-1:0] == AW'(g));
            assign par_hit = par_we && (par_addr == AW'(g));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       regs[g] <= reg_reset_value(g);
                else if (bus_hit) regs[g] <= bus_wdata;
                else if (par_hit) regs[g] <= par_wdata;
            end
        end
    endgenerate

    assign bus_rdata = bus_in_range ? regs[bus_addr[AW-1:0]] : '0;
    assign par_rdata = regs[par_addr];
    assign run_bit   = regs[0][RUN_BIT];

endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import i2c_reg_target_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         NREGS       = 4,
    parameter int         SYNC_STAGES = 2,
    parameter int         AW          = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic              par_we,
    input  logic [AW-1:0]     par_addr,
    input  logic [BYTE_W-1:0] par_wdata,
    output logic [BYTE_W-1:0] par_rdata,
    output logic              core_run
);

    logic              scl_sync;
    logic              sda_sync;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_seen;
    logic              stop_seen;
    logic              i2c_we;
    logic [BYTE_W-1:0] i2c_addr;
    logic [BYTE_W-1:0] i2c_wdata;
    logic [BYTE_W-1:0] i2c_rdata;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_sync),
        .sda_s     (sda_sync),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_seen),
        .stop_det  (stop_seen)
    );

    i2c_target_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_en     (hw_en),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_sync),
        .start_det (start_seen),
        .stop_det  (stop_seen),
        .rd_data   (i2c_rdata),
        .sda_oe    (sda_oe),
        .wr_en     (i2c_we),
        .reg_ptr   (i2c_addr),
        .wr_data   (i2c_wdata)
    );

    i2c_reg_bank #(.NREGS(NREGS), .AW(AW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (i2c_we),
        .bus_addr  (i2c_addr),
        .bus_wdata (i2c_wdata),
        .bus_rdata (i2c_rdata),
        .par_we    (par_we),
        .par_addr  (par_addr),
        .par_wdata (par_wdata),
        .par_rdata (par_rdata),
        .run_bit   (core_run)
    );

endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
    parameter int AW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hw_en,
    input logic          scl_s,
    input logic          stop_det,
    input logic          sda_oe,
    input logic          i2c_we,
    input logic [7:0]    i2c_addr,
    input logic [7:0]    i2c_wdata,
    input logic          par_we,
    input logic [AW-1:0] par_addr,
    input logic [7:0]    par_rdata
);

    // R6: disabled interface never drives the line nor commits
    a_r6_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !hw_en |-> (!sda_oe && !i2c_we));

    // R5: line drive changes only while synchronised SCL is low
    a_r5_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_en && $past(hw_en) && (sda_oe != $past(sda_oe))) |-> !scl_s);

    // R4: commits happen only with SCL low (after the LSB falling edge)
    a_r4_commit_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        i2c_we |-> !scl_s);

    // R1: after STOP the line is released
    a_r1_release_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R9: same-cycle collision keeps the bus byte
    a_r9_bus_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (i2c_we && par_we && (i2c_addr == 8'(par_addr))) |=>
        (!$stable(par_addr) || (par_rdata == $past(i2c_wdata))));

endmodule

bind i2c_reg_target i2c_reg_target_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_en     (hw_en),
    .scl_s     (scl_sync),
    .stop_det  (stop_seen),
    .sda_oe    (sda_oe),
    .i2c_we    (i2c_we),
    .i2c_addr  (i2c_addr),
    .i2c_wdata (i2c_wdata),
    .par_we    (par_we),
    .par_addr  (par_addr),
    .par_rdata (par_rdata)
);

// File: tb/i2c_reg_target_tb.sv
module i2c_reg_target_tb;

    localparam int Q  = 8;
    localparam int AW = 2;
    localparam logic [6:0] DEV = 7'h48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hw_en = 1'b1;
    logic          m_scl = 1'b1;
    logic          m_sda = 1'b1;
    logic          sda_oe;
    logic          sda_line;
    logic          par_we = 1'b0;
    logic [AW-1:0] par_addr = '0;
    logic [7:0]    par_wdata = '0;
    logic [7:0]    par_rdata;
    logic          core_run;

    int checks = 0;
    int bad    = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    assign sda_line = m_sda & ~sda_oe;

    i2c_reg_target u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_en     (hw_en),
        .scl_i     (m_scl),
        .sda_i     (sda_line),
        .sda_oe    (sda_oe),
        .par_we    (par_we),
        .par_addr  (par_addr),
        .par_wdata (par_wdata),
        .par_rdata (par_rdata),
        .core_run  (core_run)
    );

    // {rd, dev[6:0], reg[7:0], data[7:0], ack}
    localparam logic [24:0] VEC [0:8] = '{
        {1'b0, 7'h48, 8'h01, 8'hA5, 1'b1},
        {1'b1, 7'h48, 8'h01, 8'hA5, 1'b1},
        {1'b0, 7'h48, 8'h02, 8'h3C, 1'b1},
        {1'b0, 7'h49, 8'h02, 8'hFF, 1'b0},
        {1'b1, 7'h48, 8'h02, 8'h3C, 1'b1},
        {1'b0, 7'h48, 8'h03, 8'h80, 1'b1},
        {1'b1, 7'h48, 8'h03, 8'h80, 1'b1},
        {1'b0, 7'h48, 8'h07, 8'h55, 1'b1},
        {1'b1, 7'h48, 8'h07, 8'h00, 1'b1}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; wclk(Q);
        m_sda = 1'b0; wclk(Q);
        m_scl = 1'b0; wclk(Q);
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; wclk(Q);
        m_scl = 1'b1; wclk(Q);
        m_sda = 1'b0; wclk(Q);
        m_scl = 1'b0; wclk(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wclk(Q);
        m_scl = 1'b1; wclk(Q);
        m_sda = 1'b1; wclk(Q);
    endtask

    task automatic put_bit(input logic b);
        m_sda = b; wclk(Q);
        m_scl = 1'b1; wclk(2*Q);
        m_scl = 1'b0; wclk(Q);
    endtask

    task automatic put_byte(input logic [7:0] b);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
    endtask

    task automatic get_ack(output logic a);
        m_sda = 1'b1; wclk(Q);
        m_scl = 1'b1; wclk(Q);
        a = sda_oe; wclk(Q);
        m_scl = 1'b0; wclk(Q);
    endtask

    task automatic get_byte(output logic [7:0] b, output logic steady);
        logic o1;
        steady = 1'b1;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wclk(Q);
            m_scl = 1'b1; wclk(Q);
            b[i] = sda_line; o1 = sda_oe; wclk(Q);
            if (sda_oe != o1) steady = 1'b0;
            m_scl = 1'b0; wclk(Q);
        end
    endtask

    task automatic do_write(input logic [6:0] dev, input logic [7:0] ra,
                            input logic [7:0] d, output logic [2:0] acks);
        logic a;
        acks = 3'b000;
        bus_start();
        put_byte({dev, 1'b0}); get_ack(a); acks[2] = a;
        if (a) begin
            put_byte(ra); get_ack(a); acks[1] = a;
            put_byte(d);  get_ack(a); acks[0] = a;
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [6:0] dev, input logic [7:0] ra,
                           output logic [2:0] acks, output logic [7:0] d,
                           output logic steady, output logic released);
        logic a;
        acks = 3'b000; d = 8'h00; steady = 1'b1; released = 1'b1;
        bus_start();
        put_byte({dev, 1'b0}); get_ack(a); acks[2] = a;
        put_byte(ra);          get_ack(a); acks[1] = a;
        bus_rstart();
        put_byte({dev, 1'b1}); get_ack(a); acks[0] = a;
        get_byte(d, steady);
        m_sda = 1'b1; wclk(Q);
        m_scl = 1'b1; wclk(Q);
        released = !sda_oe; wclk(Q);
        m_scl = 1'b0; wclk(Q);
        bus_stop();
    endtask

    function automatic logic [7:0] peek_expected_dummy(input logic [7:0] v);
        return v;
    endfunction

    task automatic par_read(input logic [AW-1:0] a, output logic [7:0] v);
        par_addr = a; wclk(1); v = par_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] acks;
        logic [7:0] d;
        logic [7:0] v;
        logic steady, released, a;

        wclk(4);
        rst_n = 1'b1;
        wclk(4);

        // R1 reset state, R7 run bit out of reset
        check(sda_oe == 1'b0, "R1 reset sda_oe", sda_oe, 0);
        for (int r = 0; r < 4; r++) begin
            par_read(AW'(r), v);
            check(v == ((r == 0) ? 8'h01 : 8'h00), "R1 reset value", v, (r == 0) ? 1 : 0);
        end
        check(core_run == 1'b1, "R7 core_run after reset", core_run, 1);

        // table of vectors: R2 R3 R5 R8
        for (int k = 0; k < 9; k++) begin
            logic [24:0] e;
            e = VEC[k];
            if (e[24]) begin
                do_read(e[23:17], e[16:9], acks, d, steady, released);
                check(acks == 3'b111, "R5 read acks", acks, 7);
                check(d == e[8:1], "R5/R8 read data", d, e[8:1]);
                check(steady, "R5 drive only while SCL low", steady, 1);
                check(released, "R5 released at NACK", released, 1);
            end else begin
                do_write(e[23:17], e[16:9], e[8:1], acks);
                if (e[0]) check(acks == 3'b111, "R3 write acks", acks, 7);
                else      check(acks == 3'b000, "R2 mismatch no ack", acks, 0);
            end
        end
        par_read(2'd2, v);
        check(v == 8'h3C, "R2 mismatched write ignored", v, 8'h3C);
        par_read(2'd3, v);
        check(v == 8'h80, "R8 out-of-range write no alias", v, 8'h80);

        // R2 after mismatch further bytes are ignored until START/STOP
        bus_start();
        put_byte({7'h49, 1'b0}); get_ack(a);
        check(!a, "R2 mismatch address", a, 0);
        put_byte(8'h02); get_ack(a);
        check(!a, "R2 silent after mismatch", a, 0);
        bus_stop();

        // R4 commit on LSB falling edge, R9 same-cycle collision
        par_addr = 2'd1;
        bus_start();
        put_byte({DEV, 1'b0}); get_ack(a);
        put_byte(8'h01);       get_ack(a);
        for (int i = 7; i >= 1; i--) put_bit(1'(8'h5A >> i));
        m_sda = 1'b0; wclk(Q);
        m_scl = 1'b1; wclk(2*Q);
        check(par_rdata == 8'hA5, "R4 old value before LSB fall", par_rdata, 8'hA5);
        m_scl = 1'b0;
        wclk(2);
        check(par_rdata == 8'hA5, "R4 old value two edges after fall", par_rdata, 8'hA5);
        par_we = 1'b1; par_wdata = 8'hC3;
        wclk(1);
        par_we = 1'b0;
        check(par_rdata == 8'h5A, "R4/R9 bus byte after third edge", par_rdata, 8'h5A);
        wclk(Q - 3);
        get_ack(a);
        check(a, "R3 data ack", a, 1);
        bus_stop();

        // R9 plain parallel write
        par_addr = 2'd1; par_wdata = 8'h96; par_we = 1'b1; wclk(1);
        par_we = 1'b0; wclk(1);
        check(par_rdata == 8'h96, "R9 parallel write", par_rdata, 8'h96);

        // R6 hardware enable low
        hw_en = 1'b0; wclk(2);
        do_write(DEV, 8'h02, 8'h77, acks);
        check(acks == 3'b000, "R6 no ack when disabled", acks, 0);
        par_read(2'd2, v);
        check(v == 8'h3C, "R6 register untouched", v, 8'h3C);
        hw_en = 1'b1; wclk(2);

        // R7 clearing the run bit keeps the bus alive
        do_write(DEV, 8'h00, 8'h00, acks);
        check(core_run == 1'b0, "R7 core_run cleared", core_run, 0);
        do_write(DEV, 8'h03, 8'h11, acks);
        check(acks == 3'b111, "R7 write acked in shutdown", acks, 7);
        do_read(DEV, 8'h03, acks, d, steady, released);
        check(d == 8'h11, "R7 read in shutdown", d, 8'h11);
        do_write(DEV, 8'h00, 8'h01, acks);
        check(core_run == 1'b1, "R7 core_run set", core_run, 1);

        // R10 STOP right after register index
        bus_start();
        put_byte({DEV, 1'b0}); get_ack(a);
        put_byte(8'h02); get_ack(a);
        check(a, "R10 index acked", a, 1);
        bus_stop();
        par_read(2'd2, v);
        check(v == 8'h3C, "R10 stop after index no change", v, 8'h3C);

        // R10 second data byte not acked nor stored
        bus_start();
        put_byte({DEV, 1'b0}); get_ack(a);
        put_byte(8'h02); get_ack(a);
        put_byte(8'h66); get_ack(a);
        put_byte(8'h99); get_ack(a);
        check(!a, "R10 extra byte not acked", a, 0);
        bus_stop();
        par_read(2'd2, v);
        check(v == 8'h66, "R10 only first data byte stored", v, 8'h66);

        check(sda_oe == 1'b0, "R1 idle after stop", sda_oe, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule